// File: doc/BRIEF.md
# Oversampled UART Receiver with Error Flags

This block is the receive half of an asynchronous serial port. A free-running enable pulse, `os_tick_i`, arrives sixteen times per bit period. The serial line passes through a synchroniser first. The block then waits for the line to fall from its idle-high level. It takes four samples in the middle of every bit cell and accepts a start bit only when all four samples read low.

A frame has these bits, in order:
- a low start bit,
- eight data bits, least significant first,
- an even-parity bit,
- one high stop bit.

The data bits collect in a shift register. When the frame is complete, the byte moves into a one-byte hold stage and from there into a small FIFO. A reader drains the FIFO with a one-cycle read strobe.

Four sticky flags report line problems: parity, framing, overrun and break. The framing flag also covers a bit whose four samples do not all agree. A single clear strobe resets all four flags. Baud-rate generation, the transmit side and any register decoding live outside this block.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, `rx_empty_o` is 1, `err_o` is 0000 and `rd_data_o` is 0x00.
- R2: The block receives a frame of a low start bit, 8 data bits LSB first, one even-parity bit (the XOR of the data bits) and a high stop bit. The byte becomes readable without change. Bytes are read out in arrival order.
- R3: Within each bit the block samples the synchronised line at oversample ticks 7, 8, 9 and 10. Tick 0 of the start bit is the first tick that sees the line low. A start bit is accepted only if all four samples are low. Otherwise the block returns to idle with no byte stored and no flag set. The value of a data, parity or stop bit is taken from its tick-7 sample.
- R4: `err_o[0]` (parity) is set when the received parity bit differs from the XOR of the received data bits. The byte is still stored.
- R5: `err_o[1]` (framing) is set when the stop bit is low, or when the four samples of any data, parity or stop bit disagree.
- R6: The hold stage plus a 4-entry FIFO store up to 5 unread bytes. A byte that completes while both are full is dropped and sets `err_o[2]` (overrun). The 5 stored bytes are kept intact.
- R7: `err_o[3]` (break) is set when the synchronised line stays low for 177 consecutive ticks, one more than an 11-bit frame. A low run of 176 ticks does not set it.
- R8: A read strobe while the FIFO holds data presents the oldest byte on `rd_data_o` in the next cycle. A strobe while the FIFO is empty leaves `rd_data_o` and `rx_empty_o` unchanged.
- R9: The flags stay set until `clr_i` is pulsed. The pulse clears all four flags.
- R10: Only cycles with `os_tick_i` high advance the receiver. With one tick every second clock, frames of 32 clocks per bit are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Oversample enable, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Read strobe, pops the oldest byte |
| clr_i | input | 1 | Clears all error flags |
| rd_data_o | output | 8 | Byte from the last read |
| rx_empty_o | output | 1 | FIFO holds no byte |
| err_o | output | 4 | Flags: [0] parity, [1] framing, [2] overrun, [3] break |

## Verification
Each result has a fixed time at which it is due:
- **Line to receiver.** A change on `rx_i` reaches the receiver two clocks later, through the synchroniser.
- **Byte to FIFO.** The completed frame is registered one clock after the final stop-bit tick. The byte then needs one clock through the hold stage and one more into the FIFO.
- **Flags.** A flag rises one clock after the frame completes.
- **Read data.** Data from a read strobe appears on the following edge.

The bench drives the line on falling edges, waits six clocks after each stop bit before it looks, and samples every output on a falling edge. Each result is therefore settled before it is compared. Break timing is checked by run lengths of exactly 176 and 177 ticks, which sit on either side of the threshold.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

   typedef enum logic [2:0] {
      RXS_IDLE,
      RXS_START,
      RXS_DATA,
      RXS_PAR,
      RXS_STOP
   } rx_state_e;

   // flag positions inside the status vector
   localparam int FLAG_PAR = 0;
   localparam int FLAG_FRM = 1;
   localparam int FLAG_OVR = 2;
   localparam int FLAG_BRK = 3;
   localparam int FLAG_W   = 4;

   // start, parity and stop bits around the data field
   localparam int FRAME_OVERHEAD = 3;

endpackage

// File: rtl/osr_sync.sv
module osr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/osr_deframer.sv
module osr_deframer
   import osr_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OS_RATE    = 16,
   parameter int SAMP_FIRST = 7,
   parameter int SAMP_CNT   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              par_bad,
   output logic              frm_bad
);

   localparam int CNT_W = $clog2(OS_RATE);
   localparam int BIX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int SH_W  = DATA_W + 2;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
   localparam logic [CNT_W-1:0] WIN_LO   = CNT_W'(SAMP_FIRST);
   localparam logic [CNT_W-1:0] WIN_HI   = CNT_W'(SAMP_FIRST + SAMP_CNT - 1);
   localparam logic [BIX_W-1:0] BIX_LAST = BIX_W'(DATA_W - 1);

   rx_state_e           state;
   logic [CNT_W-1:0]    os_cnt;
   logic [SAMP_CNT-1:0] samp;
   logic [SH_W-1:0]     sh;
   logic [BIX_W-1:0]    bix;
   logic                mis;

   logic in_win;
   logic agree;
   logic bit_val;

   assign in_win  = (os_cnt >= WIN_LO) && (os_cnt <= WIN_HI);
   assign agree   = (samp == '0) || (&samp);
   assign bit_val = samp[SAMP_CNT-1];   // earliest of the window

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= RXS_IDLE;
         os_cnt <= '0;
         samp   <= '0;
         sh     <= '0;
         bix    <= '0;
         mis    <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (state == RXS_IDLE) begin
               if (!rx) begin
                  state  <= RXS_START;
                  os_cnt <= CNT_W'(1);
               end
            end else begin
               if (in_win) samp <= {samp[SAMP_CNT-2:0], rx};
               if (os_cnt == CNT_LAST) begin
                  os_cnt <= '0;
                  case (state)
                     RXS_START: begin
                        if (agree && !bit_val) begin
                           state <= RXS_DATA;
                           bix   <= '0;
                           mis   <= 1'b0;
                        end else begin
                           state <= RXS_IDLE;
                        end
                     end
                     RXS_DATA: begin
                        sh  <= {bit_val, sh[SH_W-1:1]};
                        mis <= mis | !agree;
                        if (bix == BIX_LAST) state <= RXS_PAR;
                        else                 bix   <= bix + 1'b1;
                     end
                     RXS_PAR: begin
                        sh    <= {bit_val, sh[SH_W-1:1]};
                        mis   <= mis | !agree;
                        state <= RXS_STOP;
                     end
                     RXS_STOP: begin
                        sh    <= {bit_val, sh[SH_W-1:1]};
                        mis   <= mis | !agree;
                        done  <= 1'b1;
                        state <= RXS_IDLE;
                     end
                     default: state <= RXS_IDLE;
                  endcase
               end else begin
                  os_cnt <= os_cnt + 1'b1;
               end
            end
         end
      end
   end

   // frame layout after the last shift: data at the bottom, parity, stop on top
   assign data    = sh[DATA_W-1:0];
   assign par_bad = sh[DATA_W] ^ (^sh[DATA_W-1:0]);
   assign frm_bad = !sh[SH_W-1] || mis;

endmodule

// File: rtl/osr_rx_buffer.sv
module osr_rx_buffer #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              ovr
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

   logic              hold_v;
   logic [DATA_W-1:0] hold_d;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr;
   logic [PTR_W-1:0]  rptr;
   logic [LVL_W-1:0]  level;

   logic full;
   logic move;
   logic pop;
   logic take;

   assign full  = (level == LVL_MAX);
   assign empty = (level == '0);
   assign move  = hold_v && !full;
   assign pop   = rd && !empty;
   assign take  = wr && (!hold_v || move);
   assign ovr   = wr && hold_v && !move;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
      end else if (take) begin
         hold_v <= 1'b1;
         hold_d <= wdata;
      end else if (move) begin
         hold_v <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (move) mem[wptr] <= hold_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         rdata <= '0;
      end else begin
         if (move) wptr <= wptr + 1'b1;
         if (pop) begin
            rptr  <= rptr + 1'b1;
            rdata <= mem[rptr];
         end
         case ({move, pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/osr_err_flags.sv
module osr_err_flags
   import osr_rx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OS_RATE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              done,
   input  logic              par_bad,
   input  logic              frm_bad,
   input  logic              ovr,
   input  logic              clr,
   output logic [FLAG_W-1:0] flags
);

   localparam int BRK_TICKS = (DATA_W + FRAME_OVERHEAD) * OS_RATE + 1;
   localparam int BRK_W     = $clog2(BRK_TICKS + 1);
   localparam logic [BRK_W-1:0] BRK_TOP = BRK_W'(BRK_TICKS);
   localparam logic [BRK_W-1:0] BRK_HIT = BRK_W'(BRK_TICKS - 1);

   logic [BRK_W-1:0]  low_run;
   logic              brk_hit;
   logic [FLAG_W-1:0] set_v;

   assign brk_hit = tick && !rx && (low_run == BRK_HIT);

   always_comb begin
      set_v           = '0;
      set_v[FLAG_PAR] = done && par_bad;
      set_v[FLAG_FRM] = done && frm_bad;
      set_v[FLAG_OVR] = ovr;
      set_v[FLAG_BRK] = brk_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
      end else if (tick) begin
         if (rx)                      low_run <= '0;
         else if (low_run != BRK_TOP) low_run <= low_run + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (clr ? '0 : flags) | set_v;
   end

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
   import osr_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OS_RATE     = 16,
   parameter int SAMP_FIRST  = 7,
   parameter int SAMP_CNT    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick_i,
   input  logic              rx_i,
   input  logic              rd_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rx_empty_o,
   output logic [FLAG_W-1:0] err_o
);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (SAMP_CNT >= 2) else $error("SAMP_CNT must be at least 2");
      assert (SAMP_FIRST >= 1) else $error("SAMP_FIRST must be at least 1");
      assert (SAMP_FIRST + SAMP_CNT <= OS_RATE - 1)
         else $error("sample window must end before the last tick");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert ((FIFO_DEPTH >= 2) && ((FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0))
         else $error("FIFO_DEPTH must be a power of two");
   end

   logic              rx_sync;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_par_bad;
   logic              fr_frm_bad;
   logic              buf_ovr;

   osr_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_i),
      .q     (rx_sync)
   );

   osr_deframer #(
      .DATA_W     (DATA_W),
      .OS_RATE    (OS_RATE),
      .SAMP_FIRST (SAMP_FIRST),
      .SAMP_CNT   (SAMP_CNT)
   ) u_deframer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick_i),
      .rx      (rx_sync),
      .done    (fr_done),
      .data    (fr_data),
      .par_bad (fr_par_bad),
      .frm_bad (fr_frm_bad)
   );

   osr_rx_buffer #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
   ) u_buffer (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (fr_done),
      .wdata (fr_data),
      .rd    (rd_i),
      .rdata (rd_data_o),
      .empty (rx_empty_o),
      .ovr   (buf_ovr)
   );

   osr_err_flags #(
      .DATA_W  (DATA_W),
      .OS_RATE (OS_RATE)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick_i),
      .rx      (rx_sync),
      .done    (fr_done),
      .par_bad (fr_par_bad),
      .frm_bad (fr_frm_bad),
      .ovr     (buf_ovr),
      .clr     (clr_i),
      .flags   (err_o)
   );

endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_i,
   input logic              clr_i,
   input logic              tick,
   input logic              done,
   input logic              par_bad,
   input logic              frm_bad,
   input logic              ovr,
   input logic [3:0]        err,
   input logic [DATA_W-1:0] rd_data,
   input logic              empty
);

   AST_PAR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && par_bad) |=> err[0]);                                 // R4

   AST_FRM_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && frm_bad) |=> err[1]);                                 // R5

   AST_OVR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> err[2]);                                               // R6

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((err & $past(err)) == $past(err)));                // R9

   AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && empty) |=> ($stable(rd_data) && empty));              // R8

   AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(tick));                                         // R10

endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_i    (rd_i),
   .clr_i   (clr_i),
   .tick    (os_tick_i),
   .done    (fr_done),
   .par_bad (fr_par_bad),
   .frm_bad (fr_frm_bad),
   .ovr     (buf_ovr),
   .err     (err_o),
   .rd_data (rd_data_o),
   .empty   (rx_empty_o)
);

// File: tb/tb_osr_uart_rx.sv
module tb_osr_uart_rx;

   localparam int CLK_PERIOD = 10;
   localparam int OS        = 16;
   localparam int WATCHDOG  = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx = 1'b1;
   logic       rd = 1'b0;
   logic       clr = 1'b0;
   logic [7:0] rd_data;
   logic       rx_empty;
   logic [3:0] err;

   int vectors   = 0;
   int miscomp   = 0;
   int tick_div  = 1;
   int tick_cnt  = 0;
   bit finished  = 1'b0;

   osr_uart_rx dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .os_tick_i  (os_tick),
      .rx_i       (rx),
      .rd_i       (rd),
      .clr_i      (clr),
      .rd_data_o  (rd_data),
      .rx_empty_o (rx_empty),
      .err_o      (err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
      os_tick  = (tick_cnt == 0);
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rx    = 1'b1;
      idle(4);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   // glitch_bit: frame bit index (0 = start) whose drive offset 10 is inverted
   task automatic send_frame(input logic [7:0] d, input bit flip_par,
                             input logic stop_v, input int glitch_bit);
      logic [10:0] f;
      int          bit_cyc;
      f       = {stop_v, (^d) ^ flip_par, d, 1'b0};
      bit_cyc = OS * tick_div;
      for (int i = 0; i < 11; i++) begin
         for (int c = 0; c < bit_cyc; c++) begin
            @(negedge clk);
            rx = (i == glitch_bit && c == 10) ? ~f[i] : f[i];
         end
      end
      @(negedge clk);
      rx = 1'b1;
   endtask

   task automatic low_run(input int n);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         rx = 1'b0;
      end
      @(negedge clk);
      rx = 1'b1;
   endtask

   task automatic read_byte(output logic [7:0] got);
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      got = rd_data;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      miscomp++;
      vectors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      logic [7:0] got;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      check("R1 empty", rx_empty, 1);
      check("R1 flags", err, 0);
      check("R1 data", rd_data, 0);

      // R2: sweep every byte value
      for (int b = 0; b < 256; b++) begin
         send_frame(8'(b), 1'b0, 1'b1, -1);
         idle(6);
         read_byte(got);
         check("R2 byte", got, b);
      end
      check("R2 clean flags", err, 0);
      check("R8 drained", rx_empty, 1);

      // R8: read while empty changes nothing
      read_byte(got);
      check("R8 empty read data", got, 8'hFF);
      check("R8 empty read flag", rx_empty, 1);

      // R3: short low pulse is not a start
      for (int c = 0; c < 3; c++) begin @(negedge clk); rx = 1'b0; end
      @(negedge clk); rx = 1'b1;
      idle(200);
      check("R3 short pulse empty", rx_empty, 1);
      check("R3 short pulse flags", err, 0);

      // R3: start whose samples disagree (low at ticks 7,8 only)
      for (int c = 0; c < 9; c++) begin @(negedge clk); rx = 1'b0; end
      @(negedge clk); rx = 1'b1;
      idle(200);
      check("R3 split start empty", rx_empty, 1);
      check("R3 split start flags", err, 0);

      // R4: wrong parity, byte kept
      send_frame(8'h5A, 1'b1, 1'b1, -1);
      idle(6);
      check("R4 parity flag", err, 4'b0001);
      idle(50);
      check("R9 sticky", err, 4'b0001);
      read_byte(got);
      check("R4 byte kept", got, 8'h5A);
      pulse_clr();
      check("R9 cleared", err, 0);

      // R5: low stop bit
      send_frame(8'hC3, 1'b0, 1'b0, -1);
      idle(6);
      check("R5 stop low", err, 4'b0010);
      read_byte(got);
      check("R5 byte", got, 8'hC3);
      pulse_clr();

      // R5: sample disagreement on data bit 1 (frame bit 2), value from tick 7
      send_frame(8'h33, 1'b0, 1'b1, 2);
      idle(6);
      check("R5 sample split", err, 4'b0010);
      read_byte(got);
      check("R3 first sample value", got, 8'h33);
      pulse_clr();

      // R6: five bytes fit, the sixth overruns
      for (int k = 0; k < 5; k++) send_frame(8'(8'h11 + k), 1'b0, 1'b1, -1);
      idle(6);
      check("R6 five fit", err, 0);
      send_frame(8'h16, 1'b0, 1'b1, -1);
      idle(6);
      check("R6 overrun", err, 4'b0100);
      for (int k = 0; k < 5; k++) begin
         read_byte(got);
         check("R6 order", got, 8'(8'h11 + k));
      end
      check("R6 dropped", rx_empty, 1);
      pulse_clr();

      // R7: break threshold on both sides
      do_reset();
      low_run(176);
      idle(40);
      check("R7 176 ticks no break", err[3], 1'b0);
      do_reset();
      low_run(177);
      idle(40);
      check("R7 177 ticks break", err[3], 1'b1);

      // R10: one tick every second clock
      do_reset();
      tick_div = 2;
      idle(4);
      send_frame(8'hA5, 1'b0, 1'b1, -1);
      idle(10);
      send_frame(8'h3C, 1'b0, 1'b1, -1);
      idle(10);
      read_byte(got);
      check("R10 slow byte 0", got, 8'hA5);
      read_byte(got);
      check("R10 slow byte 1", got, 8'h3C);
      check("R10 slow flags", err, 0);

      summary();
   end

endmodule